// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register Emulator

This block models a chain of storage stages that can either capture a whole word at once or move one bit along per clock event. All of its control pins are treated as asynchronous and are brought into a single system-clock domain. Two shift-clock pins, `tick_a` and `tick_b`, are combined with a logical OR, so a rising edge on either one can advance the chain, while the other, held high, blocks shifting. An active-low load pin copies the parallel word into every stage for as long as it is held low. While it is low, the serial output also tracks the top bit of the parallel word combinationally.

The serial output of the last stage and its inverse are driven at the ports. Several instances can be chained by feeding one instance's serial output into the next one's serial input. Both the serial input and the clock pins go through synchronizers of equal depth, so a chain shifts coherently.

The block also records two control sequences that would give unpredictable results on a discrete part. The first is `tick_b` rising while `tick_a` is low, which creates an unwanted shift edge. The second is the load pin being released while both clock pins are low. Each event sets a sticky flag that only a reset clears.

Top module: `piso_shift_emu`

## Requirements
- R1: A synchronous active-high reset clears every stage to 0, so `ser_out` is 0 and `ser_out_n` is 1. It clears both flags, and no shift occurs on the first cycles after reset.
- R2: While the synchronized `load_n` is 0, stage i takes `par_in[i]` (bit 0 to the first stage, bit STAGES-1 to the last). Any clock activity in that time has no effect.
- R3: While the synchronized `load_n` is 0, `ser_out` equals `par_in[STAGES-1]` combinationally and follows every change of that bit.
- R4: With `load_n` high, each rising edge of the synchronized `tick_a | tick_b` moves the chain one place. The synchronized `ser_in` enters stage 0, stage n moves to stage n+1, and `ser_out` shows the last stage.
- R5: `tick_b` alone can clock the register. A rising edge on `tick_b` while `tick_a` is low shifts the register.
- R6: While `tick_b` is high, edges on `tick_a` cause no shift and all stages hold.
- R7: `en_rise_err` becomes 1 when the synchronized `tick_b` rises while the synchronized `tick_a` is 0. It stays 1 until reset.
- R8: `load_rel_err` becomes 1 when the synchronized `load_n` rises while both synchronized clock pins are 0. It stays 1 until reset.
- R9: `ser_out_n` is always the inverse of `ser_out`.
- R10: When `ser_out` of one instance drives `ser_in` of a second instance, and both share the clock and load pins, the second instance receives the first one's bits in order after STAGES shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_in | input | STAGES | Parallel word, bit i to stage i |
| ser_in | input | 1 | Serial data into stage 0 |
| load_n | input | 1 | Active-low level load strobe |
| tick_a | input | 1 | Shift clock pin, OR-combined |
| tick_b | input | 1 | Active-low enable pin, OR-combined |
| ser_out | output | 1 | Last-stage value, or par_in top bit during load |
| ser_out_n | output | 1 | Inverse of ser_out |
| en_rise_err | output | 1 | Sticky: enable rose while clock low |
| load_rel_err | output | 1 | Sticky: load released with both clock pins low |

## Verification
The assertions assume that any pin change is held long enough to cross the synchronizers, so every change appears at the synchronized side as a clean level. They also assume that the load pin and a clock pin never change in the same cycle. The stimulus therefore changes one pin at a time, from the falling clock edge, and then waits four system cycles before it changes the next pin or samples. Each illegal ordering is produced once, on purpose, and is followed by a reset, so the legal sweeps run with both flags known to be clear.

// File: rtl/piso_pkg.sv
package piso_pkg;

    typedef struct packed {
        logic tick_a;
        logic tick_b;
        logic load_n;
        logic ser;
    } pins_t;

    localparam int PINS_W = $bits(pins_t);

    // Idle levels: both clock pins high so no edge fires after reset, load inactive
    localparam pins_t PINS_IDLE = '{tick_a: 1'b1, tick_b: 1'b1, load_n: 1'b1, ser: 1'b0};

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2
    } op_e;

    function automatic logic rose(input logic prev, input logic cur);
        return !prev && cur;
    endfunction

endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
    parameter int                W       = 4,
    parameter int                DEPTH   = 2,
    parameter logic [W-1:0]      RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_flop
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[DEPTH-1];
endmodule

// File: rtl/piso_ctrl.sv
module piso_ctrl
    import piso_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t now,
    output op_e   op,
    output logic  ser_bit,
    output logic  en_rise_err,
    output logic  load_rel_err
);
    logic h_a, h_b, h_load;
    logic comb_now, comb_prev;
    logic en_viol, rel_viol;

    assign comb_now  = now.tick_a | now.tick_b;
    assign comb_prev = h_a | h_b;
    assign ser_bit   = now.ser;

    always_comb begin
        if (!now.load_n)                     op = OP_LOAD;
        else if (rose(comb_prev, comb_now))  op = OP_SHIFT;
        else                                 op = OP_HOLD;
    end

    assign en_viol  = rose(h_b, now.tick_b) && !now.tick_a;
    assign rel_viol = rose(h_load, now.load_n) && !now.tick_a && !now.tick_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            h_a          <= PINS_IDLE.tick_a;
            h_b          <= PINS_IDLE.tick_b;
            h_load       <= PINS_IDLE.load_n;
            en_rise_err  <= 1'b0;
            load_rel_err <= 1'b0;
        end else begin
            h_a          <= now.tick_a;
            h_b          <= now.tick_b;
            h_load       <= now.load_n;
            en_rise_err  <= en_rise_err  | en_viol;
            load_rel_err <= load_rel_err | rel_viol;
        end
    end
endmodule

// File: rtl/piso_stages.sv
module piso_stages
    import piso_pkg::*;
#(
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [STAGES-1:0] par_in,
    input  logic              ser_bit,
    output logic [STAGES-1:0] stage_q
);
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic from_left;
        if (g == 0) begin : g_head
            assign from_left = ser_bit;
        end else begin : g_body
            assign from_left = stage_q[g-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[g] <= 1'b0;
            end else begin
                case (op)
                    OP_LOAD:  stage_q[g] <= par_in[g];
                    OP_SHIFT: stage_q[g] <= from_left;
                    default:  stage_q[g] <= stage_q[g];
                endcase
            end
        end
    end
endmodule

// File: rtl/piso_shift_emu.sv
module piso_shift_emu
    import piso_pkg::*;
#(
    parameter int STAGES     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAGES-1:0] par_in,
    input  logic              ser_in,
    input  logic              load_n,
    input  logic              tick_a,
    input  logic              tick_b,
    output logic              ser_out,
    output logic              ser_out_n,
    output logic              en_rise_err,
    output logic              load_rel_err
);
    pins_t             raw_pins;
    logic [PINS_W-1:0] sync_q;
    pins_t             now;
    op_e               op;
    logic              ser_bit;
    logic [STAGES-1:0] stage_q;

    assign raw_pins = '{tick_a: tick_a, tick_b: tick_b, load_n: load_n, ser: ser_in};

    piso_sync #(
        .W       (PINS_W),
        .DEPTH   (SYNC_DEPTH),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (sync_q)
    );

    assign now = pins_t'(sync_q);

    piso_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .now          (now),
        .op           (op),
        .ser_bit      (ser_bit),
        .en_rise_err  (en_rise_err),
        .load_rel_err (load_rel_err)
    );

    piso_stages #(.STAGES(STAGES)) u_stages (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .par_in  (par_in),
        .ser_bit (ser_bit),
        .stage_q (stage_q)
    );

    // Last stage is transparent to the top parallel bit while loading
    assign ser_out   = (op == OP_LOAD) ? par_in[STAGES-1] : stage_q[STAGES-1];
    assign ser_out_n = ~ser_out;
endmodule

// File: rtl/piso_shift_emu_chk.sv
module piso_shift_emu_chk
    import piso_pkg::*;
#(
    parameter int STAGES = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [STAGES-1:0] par_in,
    input logic [STAGES-1:0] stage_q,
    input op_e               op,
    input logic              tick_b_s,
    input logic              ser_out,
    input logic              ser_out_n,
    input logic              en_rise_err,
    input logic              load_rel_err
);
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (stage_q == '0 && !en_rise_err && !load_rel_err)); // R1

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD) |=> (stage_q == $past(par_in))); // R2

    AST_LOAD_PASS: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD) |-> (ser_out == par_in[STAGES-1])); // R3

    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHIFT) |=> (stage_q[STAGES-1:1] == $past(stage_q[STAGES-2:0]))); // R4

    AST_ENABLE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (tick_b_s && $past(tick_b_s)) |-> (op != OP_SHIFT)); // R6

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD) |=> $stable(stage_q)); // R6

    AST_EN_STICKY: assert property (@(posedge clk) disable iff (rst)
        en_rise_err |=> en_rise_err); // R7

    AST_REL_STICKY: assert property (@(posedge clk) disable iff (rst)
        load_rel_err |=> load_rel_err); // R8

    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        ser_out_n != ser_out); // R9
endmodule

bind piso_shift_emu piso_shift_emu_chk #(.STAGES(STAGES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .par_in       (par_in),
    .stage_q      (stage_q),
    .op           (op),
    .tick_b_s     (now.tick_b),
    .ser_out      (ser_out),
    .ser_out_n    (ser_out_n),
    .en_rise_err  (en_rise_err),
    .load_rel_err (load_rel_err)
);

// File: tb/piso_shift_emu_test.sv
module piso_shift_emu_test;
    localparam int PERIOD = 10;
    localparam int N      = 8;
    localparam int SETTLE = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] par_in = '0;
    logic [N-1:0] tail_par = '0;
    logic         ser_in = 1'b0;
    logic         load_n = 1'b1;
    logic         tick_a = 1'b1;
    logic         tick_b = 1'b0;
    logic         ser_out, ser_out_n, en_err, rel_err;
    logic         tail_out, tail_out_n, tail_en_err, tail_rel_err;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(PERIOD/2) clk = ~clk;

    piso_shift_emu #(.STAGES(N)) uut (
        .clk(clk), .rst(rst), .par_in(par_in), .ser_in(ser_in),
        .load_n(load_n), .tick_a(tick_a), .tick_b(tick_b),
        .ser_out(ser_out), .ser_out_n(ser_out_n),
        .en_rise_err(en_err), .load_rel_err(rel_err)
    );

    piso_shift_emu #(.STAGES(N)) uut_tail (
        .clk(clk), .rst(rst), .par_in(tail_par), .ser_in(ser_out),
        .load_n(load_n), .tick_a(tick_a), .tick_b(tick_b),
        .ser_out(tail_out), .ser_out_n(tail_out_n),
        .en_rise_err(tail_en_err), .load_rel_err(tail_rel_err)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; tick_a = 1'b1; tick_b = 1'b0; load_n = 1'b1; ser_in = 1'b0;
        cyc(3);
        rst = 1'b0;
        cyc(SETTLE);
    endtask

    task automatic pulse_a();
        tick_a = 1'b0; cyc(SETTLE);
        tick_a = 1'b1; cyc(SETTLE);
    endtask

    task automatic load_word(input logic [N-1:0] w);
        par_in = w; load_n = 1'b0; cyc(SETTLE);
        load_n = 1'b1; cyc(SETTLE);
    endtask

    initial begin
        cyc(150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 ser_out", ser_out, 1'b0);
        chk("R1 ser_out_n", ser_out_n, 1'b1);
        chk("R1 en_rise_err", en_err, 1'b0);
        chk("R1 load_rel_err", rel_err, 1'b0);

        // R2/R4/R9: every parallel word, shifted out bit by bit
        for (int p = 0; p < (1 << N); p++) begin
            logic [N-1:0] w;
            w = N'(p);
            load_word(w);
            chk("R2 first bit", ser_out, w[N-1]);
            for (int k = 1; k < N; k++) begin
                pulse_a();
                chk("R4 shifted bit", ser_out, w[N-1-k]);
                chk("R9 complement", ser_out_n, ~w[N-1-k]);
            end
        end
        chk("R7 no flag in legal sweep", en_err, 1'b0);
        chk("R8 no flag in legal sweep", rel_err, 1'b0);

        // R4: serial entry, first bit in reaches the last stage after N shifts
        begin
            logic [N-1:0] s;
            s = 8'hC9;
            load_word('0);
            for (int i = 0; i < N; i++) begin
                ser_in = s[i];
                pulse_a();
            end
            ser_in = 1'b0;
            chk("R4 serial first", ser_out, s[0]);
            for (int i = 1; i < N; i++) begin
                pulse_a();
                chk("R4 serial order", ser_out, s[i]);
            end
        end

        // R3/R2: pass-through while loading, clock ignored
        par_in = 8'h80; load_n = 1'b0; cyc(SETTLE);
        chk("R3 follow high", ser_out, 1'b1);
        par_in = 8'h00; cyc(1);
        chk("R3 follow low", ser_out, 1'b0);
        par_in = 8'h80; cyc(1);
        chk("R3 follow high again", ser_out, 1'b1);
        pulse_a();
        load_n = 1'b1; cyc(SETTLE);
        chk("R2 clock ignored while loading", ser_out, 1'b1);
        pulse_a();
        chk("R2 loaded bit6", ser_out, 1'b0);

        // R6: tick_b high blocks tick_a edges
        load_word(8'hA5);
        tick_b = 1'b1; cyc(SETTLE);
        pulse_a();
        pulse_a();
        chk("R6 held while enable high", ser_out, 1'b1);
        chk("R7 legal enable rise", en_err, 1'b0);
        tick_b = 1'b0; cyc(SETTLE);
        pulse_a();
        chk("R6 shifts after enable low", ser_out, 1'b0);

        // R5/R7: tick_b edge while tick_a low clocks and flags
        tick_a = 1'b0; cyc(SETTLE);
        tick_b = 1'b1; cyc(SETTLE);
        chk("R5 tick_b shifts", ser_out, 1'b1);
        chk("R7 flag set", en_err, 1'b1);
        tick_b = 1'b0; cyc(SETTLE);
        tick_a = 1'b1; cyc(SETTLE);
        chk("R7 flag sticky", en_err, 1'b1);
        do_reset();
        chk("R1 flag cleared", en_err, 1'b0);
        chk("R1 stages cleared", ser_out, 1'b0);

        // R8: release with both clock pins low
        par_in = 8'hFF; load_n = 1'b0; cyc(SETTLE);
        tick_a = 1'b0; cyc(SETTLE);
        load_n = 1'b1; cyc(SETTLE);
        chk("R8 flag set", rel_err, 1'b1);
        chk("R8 data kept", ser_out, 1'b1);
        tick_a = 1'b1; cyc(SETTLE);
        chk("R8 flag sticky", rel_err, 1'b1);
        do_reset();
        chk("R1 release flag cleared", rel_err, 1'b0);

        // R10: two instances in a chain
        begin
            logic [N-1:0] head_w, tail_w;
            head_w = 8'h3C; tail_w = 8'h96;
            tail_par = tail_w;
            load_word(head_w);
            chk("R10 tail first", tail_out, tail_w[N-1]);
            for (int k = 1; k < 2 * N; k++) begin
                pulse_a();
                if (k < N) chk("R10 tail own bit", tail_out, tail_w[N-1-k]);
                else       chk("R10 head bit in tail", tail_out, head_w[2*N-1-k]);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule